// File: doc/BRIEF.md
# Display Enable Power Sequencer

This block owns the panel's display-enable pin across power-up and power-down. When the enable request rises, it waits a programmable number of frames, counted on the frame-start strobe of the video timing generator, before it drives the pin to its active level. When the request falls, it drops the pin first. It then waits the same number of frames before it reports that the panel is fully off. This gives the panel supply and backlight the settling time they need on both sides of the enable edge.

The pin never moves at an arbitrary moment. In the default alignment mode it changes only on the trailing (falling) edge of the horizontal sync pulse. In the relaxed mode it may change on either edge of that pulse. A polarity input selects whether the pin is active high or active low, and the pin's level follows that input without delay. Two flags report the state: one is high while the display is fully on, and one is high while the sequence is fully off.

Top module: `disp_pwr_seq`

## Requirements
- R1: While reset is asserted and right after it, the block is fully off: `disp_on_o`=0, `pwr_off_o`=1, and `disp_o` equals `disp_pol_i`, which is the inactive level.
- R2: `disp_o` is `~disp_pol_i` while the display is on and `disp_pol_i` otherwise (polarity 0 = active high, 1 = active low). A change of `disp_pol_i` shows on the pin without waiting for a clock.
- R3: A high `enable_i` seen while off starts the startup guard and loads `guard_frames_i`. Each later `frame_start_i` strobe lowers the remaining count by one, and a strobe in the loading cycle is not counted. The display turns on at the first permitted hsync edge in a cycle that follows the one in which the count reached zero.
- R4: A low `enable_i` while on drops the display at the next permitted hsync edge and starts the shutdown guard with a fresh `guard_frames_i` count. `pwr_off_o` rises on the clock after the one that counts the last strobe.
- R5: With `any_edge_i`=0, the only permitted edge is an hsync falling edge: `hsync_i` high in the previous cycle and low in this one. A rising edge changes nothing.
- R6: With `any_edge_i`=1, both a rising and a falling hsync edge are permitted.
- R7: A guard count of 0 adds no frames. Startup turns on at the next permitted edge after the entry cycle, and shutdown reaches off one clock after it starts.
- R8: A low `enable_i` during the startup guard abandons the count on the next clock and enters the shutdown guard with a fresh count. The pin stays inactive throughout.
- R9: `disp_on_o` is high only in the on state, and `pwr_off_o` is high only in the off state.
- R10: A high `enable_i` during the shutdown guard does not shorten it. The block first reaches off for one clock and starts the startup guard on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| enable_i | input | 1 | Level request: 1 = display wanted on |
| frame_start_i | input | 1 | One-cycle strobe at the start of each frame |
| hsync_i | input | 1 | Horizontal sync pulse, active high |
| guard_frames_i | input | GUARD_W | Number of frames in each guard interval |
| disp_pol_i | input | 1 | Pin polarity: 0 active high, 1 active low |
| any_edge_i | input | 1 | 0: change on hsync falling edge only; 1: either edge |
| disp_o | output | 1 | Display-enable pin |
| disp_on_o | output | 1 | High while the display is fully on |
| pwr_off_o | output | 1 | High while the sequence is fully off |

## Verification
The hardest situations to reach are those where two conditions must coincide: the startup count reaching zero exactly as an hsync edge arrives, or an enable request reversing partway through a guard. The directed phase places frame strobes and hsync edges cycle by cycle to set up each of these, including an abort during startup and a re-enable during shutdown. A long stretch of randomized traffic then drives all inputs together against a behavioural reference model. In that traffic, short guard counts and frequent hsync toggles make the coincidences common.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  typedef enum logic [1:0] {
    PS_OFF       = 2'd0,
    PS_RAMP_UP   = 2'd1,
    PS_ON        = 2'd2,
    PS_RAMP_DOWN = 2'd3
  } pwr_state_e;

  localparam int unsigned DEFAULT_GUARD_W = 8;

endpackage

// File: rtl/hsync_edge_gate.sv
module hsync_edge_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic any_edge_i,
  output logic permit_o
);

  logic hs_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_q <= 1'b0;
    else         hs_q <= hsync_i;
  end

  always_comb begin
    rise     = hsync_i & ~hs_q;
    fall     = ~hsync_i & hs_q;
    permit_o = any_edge_i ? (rise | fall) : fall;
  end

  // R5: in trailing-edge mode a rising hsync never grants a change
  assert_rise_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_edge_i && hsync_i) |-> !permit_o)
    else $error("rising hsync permitted in trailing-edge mode");

endmodule

// File: rtl/frame_guard_cnt.sv
module frame_guard_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    zero_o = (cnt_q == '0);
    cnt_en = load_i | (tick_i & ~zero_o);
    cnt_d  = load_i ? load_val_i : (cnt_q - {{(CNT_W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: once exhausted the count stays at zero until reloaded (no wrap)
  assert_zero_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o)
    else $error("guard count wrapped below zero");

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import disp_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       permit_i,
  input  logic       guard_done_i,
  output logic       load_o,
  output pwr_state_e state_o
);

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    case (state_q)
      PS_OFF: begin
        if (enable_i) begin
          state_d = PS_RAMP_UP;
          load_o  = 1'b1;
        end
      end
      PS_RAMP_UP: begin
        if (!enable_i) begin
          state_d = PS_RAMP_DOWN;
          load_o  = 1'b1;
        end else if (guard_done_i && permit_i) begin
          state_d = PS_ON;
        end
      end
      PS_ON: begin
        if (!enable_i && permit_i) begin
          state_d = PS_RAMP_DOWN;
          load_o  = 1'b1;
        end
      end
      PS_RAMP_DOWN: begin
        if (guard_done_i) state_d = PS_OFF;
      end
      default: state_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R3: startup holds while frames remain and enable stays high
  assert_startup_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RAMP_UP && enable_i && !guard_done_i) |=> state_q == PS_RAMP_UP)
    else $error("startup guard ended early");

  // R4: the display stays on until a permitted edge
  assert_on_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_ON && !permit_i) |=> state_q == PS_ON)
    else $error("display left on-state without a permitted edge");

  // R8: disable during startup abandons it on the next clock
  assert_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RAMP_UP && !enable_i) |=> state_q == PS_RAMP_DOWN)
    else $error("startup abort did not enter shutdown guard");

  // R10: shutdown guard is never shortened by a new request
  assert_shutdown_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RAMP_DOWN && !guard_done_i) |=> state_q == PS_RAMP_DOWN)
    else $error("shutdown guard cut short");

  // R6: entry into on-state always coincides with a permitted edge
  assert_on_entry_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PS_ON && state_d == PS_ON) |-> (permit_i && guard_done_i))
    else $error("display turned on without edge and finished guard");

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import disp_seq_pkg::*;
#(
  parameter int unsigned GUARD_W = DEFAULT_GUARD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               frame_start_i,
  input  logic               hsync_i,
  input  logic [GUARD_W-1:0] guard_frames_i,
  input  logic               disp_pol_i,
  input  logic               any_edge_i,
  output logic               disp_o,
  output logic               disp_on_o,
  output logic               pwr_off_o
);

  logic       permit;
  logic       guard_done;
  logic       load;
  pwr_state_e state;

  hsync_edge_gate u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsync_i    (hsync_i),
    .any_edge_i (any_edge_i),
    .permit_o   (permit)
  );

  frame_guard_cnt #(.CNT_W(GUARD_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (guard_frames_i),
    .tick_i     (frame_start_i),
    .zero_o     (guard_done)
  );

  pwr_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .permit_i     (permit),
    .guard_done_i (guard_done),
    .load_o       (load),
    .state_o      (state)
  );

  always_comb begin
    disp_on_o = (state == PS_ON);
    pwr_off_o = (state == PS_OFF);
    disp_o    = disp_on_o ^ disp_pol_i;
  end

  // R9: the two status flags are never high together
  assert_flags_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(disp_on_o && pwr_off_o))
    else $error("on and off flags both high");

  // R1: off-state drives the pin to the inactive level
  assert_off_inactive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o |-> (disp_o == disp_pol_i))
    else $error("pin active while fully off");

endmodule

// File: tb/sim_disp_pwr_seq.sv
module sim_disp_pwr_seq;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       enable_i;
  logic       frame_start_i;
  logic       hsync_i;
  logic [7:0] guard_frames_i;
  logic       disp_pol_i;
  logic       any_edge_i;
  logic       disp_o;
  logic       disp_on_o;
  logic       pwr_off_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;

  always #4 clk_i = ~clk_i;

  disp_pwr_seq #(.GUARD_W(8)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .frame_start_i(frame_start_i), .hsync_i(hsync_i),
    .guard_frames_i(guard_frames_i), .disp_pol_i(disp_pol_i),
    .any_edge_i(any_edge_i), .disp_o(disp_o), .disp_on_o(disp_on_o),
    .pwr_off_o(pwr_off_o)
  );

  // behavioural reference: 0 off, 1 starting, 2 on, 3 stopping
  int mst = 0;
  int mcnt = 0;
  int mhs = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst = 0; mcnt = 0; mhs = 0;
    end else begin
      bit ok;
      bit done;
      bit ld;
      ok   = any_edge_i ? (int'(hsync_i) != mhs) : (mhs == 1 && !hsync_i);
      done = (mcnt == 0);
      ld   = 1'b0;
      if (mst == 0) begin
        if (enable_i) begin mst = 1; ld = 1'b1; end
      end else if (mst == 1) begin
        if (!enable_i) begin mst = 3; ld = 1'b1; end
        else if (done && ok) mst = 2;
      end else if (mst == 2) begin
        if (!enable_i && ok) begin mst = 3; ld = 1'b1; end
      end else begin
        if (done) mst = 0;
      end
      if (ld) mcnt = int'(guard_frames_i);
      else if (frame_start_i && mcnt > 0) mcnt = mcnt - 1;
      mhs = int'(hsync_i);
    end
  end

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    cycles++;
    if (cmp_en) begin
      int e_on;
      int e_off;
      int e_disp;
      e_on   = (mst == 2) ? 1 : 0;
      e_off  = (mst == 0) ? 1 : 0;
      e_disp = e_on ^ int'(disp_pol_i);
      check(int'(disp_o) == e_disp, "R2", "model disp_o", int'(disp_o), e_disp);
      check(int'(disp_on_o) == e_on && int'(pwr_off_o) == e_off, "R9",
            "model flags on*2+off", int'(disp_on_o)*2 + int'(pwr_off_o), e_on*2 + e_off);
    end
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 200000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic frame();
    frame_start_i = 1'b1;
    cyc(1);
    frame_start_i = 1'b0;
  endtask

  task automatic hs(input bit v);
    hsync_i = v;
    cyc(1);
  endtask

  initial begin
    rst_ni = 1'b0; enable_i = 1'b0; frame_start_i = 1'b0; hsync_i = 1'b0;
    guard_frames_i = 8'd3; disp_pol_i = 1'b1; any_edge_i = 1'b0;
    cyc(2);
    check(disp_o == 1'b1, "R1", "reset pin pol=1", int'(disp_o), 1);
    check(pwr_off_o == 1'b1 && disp_on_o == 1'b0, "R1", "reset flags off", int'(pwr_off_o), 1);
    disp_pol_i = 1'b0;
    #1;
    check(disp_o == 1'b0, "R1", "reset pin pol=0", int'(disp_o), 0);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    cyc(2);
    check(pwr_off_o == 1'b1, "R1", "off after release", int'(pwr_off_o), 1);

    // startup, trailing-edge mode, guard 3
    enable_i = 1'b1;
    cyc(1);
    check(pwr_off_o == 1'b0 && disp_on_o == 1'b0, "R3", "startup entered", int'(pwr_off_o), 0);
    hs(1); hs(0);
    check(disp_o == 1'b0, "R3", "no turn-on before frames", int'(disp_o), 0);
    frame(); frame(); frame();
    check(disp_o == 1'b0, "R3", "still off after count", int'(disp_o), 0);
    hs(1);
    check(disp_on_o == 1'b0, "R5", "rising edge ignored", int'(disp_on_o), 0);
    hs(0);
    check(disp_on_o == 1'b1 && disp_o == 1'b1, "R3", "on at falling edge", int'(disp_o), 1);

    // shutdown from on
    enable_i = 1'b0;
    cyc(2);
    check(disp_on_o == 1'b1, "R4", "waits for edge", int'(disp_on_o), 1);
    hs(1);
    check(disp_on_o == 1'b1, "R5", "rising edge does not drop", int'(disp_on_o), 1);
    hs(0);
    check(disp_o == 1'b0 && pwr_off_o == 1'b0, "R4", "dropped, guard running", int'(disp_o), 0);
    frame(); frame(); frame();
    check(pwr_off_o == 1'b0, "R4", "not off at last strobe", int'(pwr_off_o), 0);
    cyc(1);
    check(pwr_off_o == 1'b1, "R4", "off after guard", int'(pwr_off_o), 1);

    // any-edge mode, guard 0
    any_edge_i = 1'b1; guard_frames_i = 8'd0; enable_i = 1'b1;
    cyc(1);
    check(disp_on_o == 1'b0, "R7", "not on in entry cycle", int'(disp_on_o), 0);
    hs(1);
    check(disp_on_o == 1'b1, "R6", "on at rising edge", int'(disp_on_o), 1);
    enable_i = 1'b0;
    hs(0);
    check(disp_on_o == 1'b0 && pwr_off_o == 1'b0, "R7", "zero guard shutdown", int'(pwr_off_o), 0);
    cyc(1);
    check(pwr_off_o == 1'b1, "R7", "off one clock later", int'(pwr_off_o), 1);

    // abort during startup, guard 5
    any_edge_i = 1'b0; guard_frames_i = 8'd5; enable_i = 1'b1;
    cyc(1);
    frame(); frame();
    enable_i = 1'b0;
    cyc(1);
    check(pwr_off_o == 1'b0 && disp_o == 1'b0, "R8", "aborted into guard", int'(pwr_off_o), 0);
    frame(); frame(); frame(); frame();
    check(pwr_off_o == 1'b0, "R8", "fresh count still running", int'(pwr_off_o), 0);
    frame();
    cyc(1);
    check(pwr_off_o == 1'b1, "R8", "off after fresh count", int'(pwr_off_o), 1);

    // re-enable during shutdown, guard 2, any-edge
    any_edge_i = 1'b1; guard_frames_i = 8'd2; enable_i = 1'b1;
    cyc(1);
    frame(); frame();
    hs(1);
    check(disp_on_o == 1'b1, "R6", "on before polarity test", int'(disp_on_o), 1);
    disp_pol_i = 1'b1;
    #1;
    check(disp_o == 1'b0, "R2", "active low while on", int'(disp_o), 0);
    disp_pol_i = 1'b0;
    enable_i = 1'b0;
    hs(0);
    enable_i = 1'b1;
    frame();
    check(disp_on_o == 1'b0 && pwr_off_o == 1'b0, "R10", "re-enable ignored", int'(disp_on_o), 0);
    hs(1);
    check(disp_on_o == 1'b0, "R10", "edge ignored in guard", int'(disp_on_o), 0);
    frame();
    cyc(1);
    check(pwr_off_o == 1'b1, "R10", "reaches off first", int'(pwr_off_o), 1);
    cyc(1);
    check(pwr_off_o == 1'b0 && disp_on_o == 1'b0, "R10", "startup follows", int'(pwr_off_o), 0);
    frame(); frame();
    hs(0);
    check(disp_on_o == 1'b1, "R10", "on after new startup", int'(disp_on_o), 1);
    enable_i = 1'b0;
    hs(1);
    frame(); frame();
    cyc(1);
    check(pwr_off_o == 1'b1, "R9", "off flag back", int'(pwr_off_o), 1);

    // randomized traffic against the reference model
    for (int i = 0; i < 6000; i++) begin
      int unsigned r;
      r = $urandom;
      if (r % 53 == 0) enable_i = ~enable_i;
      if (r % 211 == 1) any_edge_i = ~any_edge_i;
      if (r % 307 == 2) disp_pol_i = ~disp_pol_i;
      if (r % 101 == 3) guard_frames_i = 8'(($urandom) % 4);
      if ((r >> 8) % 5 == 0) hsync_i = ~hsync_i;
      frame_start_i = ((r >> 16) % 17 == 0);
      cyc(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule